// File: doc/BRIEF.md
# TDM Timeslot PRBS Bit-Error-Rate Tester

This block measures bit errors on a single timeslot of a multi-stream serial TDM frame. Every stream is one serial line, and all streams share one bit clock and one frame pulse. A position counter, restarted by the frame pulse, tracks which channel and which bit of that channel is on the lines. On the transmit side, a 15-bit linear feedback generator (x^15 + x^14 + 1) places its bits into whichever timeslot has its per-slot connection word set to pattern mode. Every other timeslot on every stream carries the idle byte 0xFF.

On the receive side, a selection register chooses one input stream and channel. The checker shifts the incoming bits of that slot into its own register until its predictions have held for fifteen bits in a row. It then runs on its own predictions and counts every incoming bit that disagrees with them. Software controls the test through a small register bus. A run bit gates the error count, and a clear bit holds the count at zero. The saturating error count can be read back over the same bus.

The intended flow has five steps. First, arm one output slot through the connection memory and wire it back to an input externally. Second, select that input slot. Third, pulse the clear bit to discard errors seen before lock. Fourth, set the run bit for the test interval. Fifth, stop the test and read the count.

Top module: `tdm_ber_tester`

## Requirements
- R1: A frame pulse sampled high at a clock edge makes the following cycle bit 0 of channel 0. Each channel then occupies SLOT_BITS consecutive cycles, and the channels follow each other in ascending order.
- R2: A timeslot whose connection word has bits [15:13] equal to 3'b111 carries the generator output (x^15 + x^14 + 1, register all ones after reset, first bit sent is the register MSB). It carries SLOT_BITS bits per occurrence, and the generator advances only during such a slot.
- R3: Every timeslot not in pattern mode drives 1 on every bit. This includes a slot rewritten with any other value in bits [15:13].
- R4: The selection register at address 0x11 holds the receive stream in bits [15:8] and the receive channel in bits [7:0]. It reads back in the same layout; for example, 0x0101 selects stream 1, channel 1.
- R5: The checker counts nothing until fifteen consecutive incoming bits of the selected slot have matched its prediction. An all-zero shift register never contributes a match.
- R6: With bit 9 (run) of the control register at 0x00 cleared, mismatches do not change the error count.
- R7: While bit 10 (clear) of the control register is set, the error count reads zero and stays zero whatever arrives.
- R8: While running and locked, each mismatching received bit of the selected slot adds exactly one to the count, which reads at address 0x12, zero-extended to 16 bits.
- R9: The error count saturates at its maximum value (2^ERR_W - 1).
- R10: After reset all output lines are 1 and the control, selection and count registers read zero.
- R11: Any write to the selection register drops lock and restarts synchronisation, so mismatches during the resynchronisation are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by all streams |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Frame start marker; the next cycle is channel 0, bit 0 |
| rx_data | input | N_STREAMS | Serial input lines, one per stream |
| tx_data | output | N_STREAMS | Serial output lines, one per stream |
| cm_we | input | 1 | Connection-memory write strobe |
| cm_addr | input | SW+CW | Connection-memory address {stream, channel} |
| cm_wdata | input | 16 | Connection word; bits [15:13] give the slot mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |

## Verification
The hardest condition to reach from the ports is a locked checker that then sees errors. Lock needs about four frames of clean, correctly aligned pattern before any corruption can be counted. The bench loops every output line back to its input and overlays an injection mask that a frame-aware monitor drives only in the selected slot. This lets corruption be timed to land after lock, during a resynchronisation, or while run or clear is in a given state. Saturation is reached by building the bench's instance with a narrow counter and corrupting whole slots for several frames.

// File: rtl/tdm_ber_pkg.sv
package tdm_ber_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 8;
  localparam int PRBS_W   = 15;
  localparam int LOCK_RUN = 15;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_SEL  = 8'h11;
  localparam logic [ADDR_W-1:0] ADDR_ERRS = 8'h12;

  localparam int CTRL_RUN_BIT = 9;
  localparam int CTRL_CLR_BIT = 10;

  localparam logic [2:0] MODE_PATTERN = 3'b111;

  // x^15 + x^14 + 1: new bit is the XOR of the two oldest bits
  function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_W-2]};
  endfunction
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int FRAME_LEN = 256,
  localparam int POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_pulse,
  output logic [POS_W-1:0] slot_pos
);
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    if (frame_pulse)
      pos_d = '0;
    else if (pos_q == POS_W'(FRAME_LEN - 1))
      pos_d = '0;
    else
      pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign slot_pos = pos_q;
endmodule

// File: rtl/tdm_prbs_gen.sv
module tdm_prbs_gen
  import tdm_ber_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic bit_out
);
  logic [PRBS_W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (advance) lfsr_d = prbs_step(lfsr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= '1;
    else        lfsr_q <= lfsr_d;
  end

  assign bit_out = lfsr_q[PRBS_W-1];
endmodule

// File: rtl/tdm_prbs_rx.sv
module tdm_prbs_rx
  import tdm_ber_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             rx_bit,
  input  logic             resync,
  input  logic             run,
  input  logic             clr,
  output logic             locked,
  output logic [ERR_W-1:0] err_cnt
);
  localparam int HIT_W = $clog2(LOCK_RUN + 1);

  logic [PRBS_W-1:0] sh_q, sh_d;
  logic [HIT_W-1:0]  hits_q, hits_d;
  logic              lock_q, lock_d;
  logic [ERR_W-1:0]  cnt_q, cnt_d;
  logic              pred, mismatch;

  always_comb begin
    pred     = sh_q[PRBS_W-1] ^ sh_q[PRBS_W-2];
    mismatch = sample_en && (rx_bit != pred);
    sh_d     = sh_q;
    hits_d   = hits_q;
    lock_d   = lock_q;
    cnt_d    = cnt_q;
    if (resync) begin
      sh_d   = '0;
      hits_d = '0;
      lock_d = 1'b0;
    end else if (sample_en) begin
      if (lock_q) begin
        sh_d = {sh_q[PRBS_W-2:0], pred};
      end else begin
        sh_d = {sh_q[PRBS_W-2:0], rx_bit};
        if (!mismatch && (sh_q != '0)) begin
          hits_d = hits_q + 1'b1;
          if (hits_q == HIT_W'(LOCK_RUN - 1)) lock_d = 1'b1;
        end else begin
          hits_d = '0;
        end
      end
    end
    if (clr)
      cnt_d = '0;
    else if (run && lock_q && mismatch && (cnt_q != '1))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hits_q <= '0;
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      hits_q <= hits_d;
      lock_q <= lock_d;
      cnt_q  <= cnt_d;
    end
  end

  assign locked  = lock_q;
  assign err_cnt = cnt_q;
endmodule

// File: rtl/tdm_ber_tester.sv
module tdm_ber_tester
  import tdm_ber_pkg::*;
#(
  parameter int N_STREAMS  = 8,
  parameter int N_CHANNELS = 32,
  parameter int SLOT_BITS  = 8,
  parameter int ERR_W      = 16,
  localparam int SW        = $clog2(N_STREAMS),
  localparam int CW        = $clog2(N_CHANNELS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_pulse,
  input  logic [N_STREAMS-1:0] rx_data,
  output logic [N_STREAMS-1:0] tx_data,
  input  logic                 cm_we,
  input  logic [SW+CW-1:0]     cm_addr,
  input  logic [DATA_W-1:0]    cm_wdata,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata
);
  localparam int FRAME_LEN = N_CHANNELS * SLOT_BITS;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int BIT_W     = POS_W - CW;
  localparam int N_SLOTS   = N_STREAMS * N_CHANNELS;

  logic [POS_W-1:0]   slot_pos;
  logic [CW-1:0]      chan;
  logic [N_SLOTS-1:0] pat_map_q, pat_map_d;
  logic [N_STREAMS-1:0] slot_pat;
  logic               prbs_bit;
  logic               run_q, run_d, clr_q, clr_d;
  logic [SW-1:0]      sel_st_q, sel_st_d;
  logic [CW-1:0]      sel_ch_q, sel_ch_d;
  logic               sel_wr;
  logic               rx_locked;
  logic [ERR_W-1:0]   err_cnt;
  logic               unused_bits;

  tdm_slot_counter #(.FRAME_LEN(FRAME_LEN)) u_slot (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .slot_pos(slot_pos)
  );

  assign chan = slot_pos[POS_W-1:BIT_W];

  // Transmit side: one pattern flag per timeslot
  always_comb begin
    pat_map_d = pat_map_q;
    if (cm_we) pat_map_d[cm_addr] = (cm_wdata[15:13] == MODE_PATTERN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pat_map_q <= '0;
    else        pat_map_q <= pat_map_d;
  end

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_tx
    assign slot_pat[s] = pat_map_q[{SW'(s), chan}];
    assign tx_data[s]  = slot_pat[s] ? prbs_bit : 1'b1;
  end

  tdm_prbs_gen u_gen (
    .clk(clk), .rst_n(rst_n), .advance(|slot_pat), .bit_out(prbs_bit)
  );

  // Control and selection registers
  assign sel_wr = reg_we && (reg_addr == ADDR_SEL);

  always_comb begin
    run_d    = run_q;
    clr_d    = clr_q;
    sel_st_d = sel_st_q;
    sel_ch_d = sel_ch_q;
    if (reg_we && (reg_addr == ADDR_CTRL)) begin
      run_d = reg_wdata[CTRL_RUN_BIT];
      clr_d = reg_wdata[CTRL_CLR_BIT];
    end
    if (sel_wr) begin
      sel_st_d = reg_wdata[8 +: SW];
      sel_ch_d = reg_wdata[0 +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      clr_q    <= 1'b0;
      sel_st_q <= '0;
      sel_ch_q <= '0;
    end else begin
      run_q    <= run_d;
      clr_q    <= clr_d;
      sel_st_q <= sel_st_d;
      sel_ch_q <= sel_ch_d;
    end
  end

  // Receive side
  tdm_prbs_rx #(.ERR_W(ERR_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sample_en(chan == sel_ch_q),
    .rx_bit(rx_data[sel_st_q]),
    .resync(sel_wr),
    .run(run_q), .clr(clr_q),
    .locked(rx_locked), .err_cnt(err_cnt)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_RUN_BIT] = run_q;
        reg_rdata[CTRL_CLR_BIT] = clr_q;
      end
      ADDR_SEL: begin
        reg_rdata[8 +: SW] = sel_st_q;
        reg_rdata[0 +: CW] = sel_ch_q;
      end
      ADDR_ERRS: reg_rdata[ERR_W-1:0] = err_cnt;
      default:   reg_rdata = '0;
    endcase
  end

  assign unused_bits = ^{cm_wdata, reg_wdata, slot_pos};
endmodule

// File: rtl/tdm_ber_tester_sva.sv
module tdm_ber_tester_sva #(
  parameter int ERR_W = 16,
  parameter int POS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_pulse,
  input logic [POS_W-1:0] slot_pos,
  input logic             run,
  input logic             clr,
  input logic             locked,
  input logic [ERR_W-1:0] err_cnt
);
  assert_frame_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> (slot_pos == '0));

  assert_unlocked_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !clr) |=> $stable(err_cnt));

  assert_stopped_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(err_cnt));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_cnt == '0));

  assert_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_cnt == $past(err_cnt)) || (err_cnt == ERR_W'($past(err_cnt) + 1'b1))));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_cnt == '1) && !clr) |=> (err_cnt == '1));
endmodule

bind tdm_ber_tester tdm_ber_tester_sva #(.ERR_W(ERR_W), .POS_W(POS_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .slot_pos(slot_pos),
  .run(run_q), .clr(clr_q), .locked(rx_locked), .err_cnt(err_cnt)
);

// File: tb/tdm_ber_tester_tb.sv
`timescale 1ns/1ps
module tdm_ber_tester_tb_top;
  localparam int NS    = 8;
  localparam int NC    = 32;
  localparam int SB    = 8;
  localparam int EW    = 6;
  localparam int FRAME = NC * SB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_pulse;
  logic [NS-1:0] rx_data, tx_data, inj_vec;
  logic          cm_we;
  logic [7:0]    cm_addr;
  logic [15:0]   cm_wdata;
  logic          reg_we;
  logic [7:0]    reg_addr;
  logic [15:0]   reg_wdata, reg_rdata;

  int checks = 0;
  int fails  = 0;

  // bench view of the setup
  logic          pat_en = 1'b0;
  int            pat_st = 1, pat_ch = 1;
  int            rx_st = 0, rx_ch = 0;
  logic [14:0]   model = 15'h7FFF;
  int            tx_seen = 0, tx_mis = 0, idle_mis = 0;
  int            inj_left = 0;
  logic          force_fp = 1'b0;
  logic          mon_on = 1'b0;
  int            tb_pos = 0;
  logic [15:0]   rd;

  always #2.5 clk = ~clk;

  assign rx_data = tx_data ^ inj_vec;

  tdm_ber_tester #(.N_STREAMS(NS), .N_CHANNELS(NC), .SLOT_BITS(SB), .ERR_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .rx_data(rx_data),
    .tx_data(tx_data), .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Frame-aware monitor: checks outputs, drives frame pulse and error injection
  initial begin
    frame_pulse = 1'b0;
    inj_vec     = '0;
    wait (mon_on);
    forever begin
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
        if (pat_en && s == pat_st && (tb_pos / SB) == pat_ch) begin
          tx_seen++;
          if (tx_data[s] != model[14]) tx_mis++;
        end else if (tx_data[s] != 1'b1) begin
          idle_mis++;
        end
      end
      if (pat_en && (tb_pos / SB) == pat_ch) model = {model[13:0], model[14] ^ model[13]};
      inj_vec = '0;
      if (inj_left > 0 && (tb_pos / SB) == rx_ch) begin
        inj_vec[rx_st] = 1'b1;
        inj_left--;
      end
      frame_pulse = (tb_pos == FRAME - 1) || force_fp;
      force_fp = 1'b0;
      tb_pos = frame_pulse ? 0 : tb_pos + 1;
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr_cm(input int st, input int ch, input logic [15:0] w, input logic en);
    @(posedge clk); #1;
    cm_we = 1'b1; cm_addr = {3'(st), 5'(ch)}; cm_wdata = w;
    @(posedge clk); #1;
    cm_we = 1'b0;
    pat_en = en; pat_st = st; pat_ch = ch;
  endtask

  task automatic select_rx(input int st, input int ch);
    wr_reg(8'h11, {8'(st), 8'(ch)});
    rx_st = st; rx_ch = ch;
  endtask

  task automatic frames(input int n);
    repeat (n * FRAME) @(posedge clk);
    #1;
  endtask

  task automatic inject(input int n);
    @(posedge clk); #1;
    inj_left = n;
  endtask

  task automatic t_reset;
    check("R10 tx lines idle", int'(tx_data), 255);
    rd_reg(8'h00, rd); check("R10 control zero", int'(rd), 0);
    rd_reg(8'h11, rd); check("R10 select zero", int'(rd), 0);
    rd_reg(8'h12, rd); check("R10 count zero", int'(rd), 0);
  endtask

  task automatic t_pattern;
    wr_cm(1, 1, 16'hE000, 1'b1);
    select_rx(1, 1);
    rd_reg(8'h11, rd); check("R4 select readback", int'(rd), 16'h0101);
    tx_seen = 0; tx_mis = 0; idle_mis = 0;
    frames(3);
    check("R2 pattern bits seen", tx_seen, 3 * SB);
    check("R2 pattern mismatches", tx_mis, 0);
    check("R3 idle mismatches", idle_mis, 0);
  endtask

  task automatic t_realign;
    frames(1);
    repeat (77) @(posedge clk);
    #1 force_fp = 1'b1;
    tx_seen = 0; tx_mis = 0; idle_mis = 0;
    frames(2);
    check("R1 realigned pattern mismatches", tx_mis, 0);
    check("R1 realigned idle mismatches", idle_mis, 0);
  endtask

  task automatic t_count;
    frames(4);
    wr_reg(8'h00, 16'h0400);
    rd_reg(8'h12, rd); check("R7 clear before run", int'(rd), 0);
    wr_reg(8'h00, 16'h0200);
    frames(1);
    rd_reg(8'h12, rd); check("R5 locked clean run", int'(rd), 0);
    inject(5);
    frames(2);
    rd_reg(8'h12, rd); check("R8 five injected", int'(rd), 5);
  endtask

  task automatic t_stop;
    wr_reg(8'h00, 16'h0000);
    inject(3);
    frames(2);
    rd_reg(8'h12, rd); check("R6 stopped count held", int'(rd), 5);
  endtask

  task automatic t_clear;
    wr_reg(8'h00, 16'h0600);
    rd_reg(8'h12, rd); check("R7 clear zeroes", int'(rd), 0);
    inject(2);
    frames(2);
    rd_reg(8'h12, rd); check("R7 held zero while set", int'(rd), 0);
    wr_reg(8'h00, 16'h0200);
    frames(1);
    rd_reg(8'h12, rd); check("R7 zero after release", int'(rd), 0);
  endtask

  task automatic t_resync;
    select_rx(1, 1);
    inject(4);
    frames(6);
    rd_reg(8'h12, rd); check("R11 resync errors ignored", int'(rd), 0);
    inject(3);
    frames(2);
    rd_reg(8'h12, rd); check("R11 relocked counts", int'(rd), 3);
  endtask

  task automatic t_unlocked;
    select_rx(1, 2);
    wr_reg(8'h00, 16'h0400);
    wr_reg(8'h00, 16'h0200);
    inject(6);
    frames(3);
    rd_reg(8'h12, rd); check("R5 no lock on idle slot", int'(rd), 0);
  endtask

  task automatic t_saturate;
    select_rx(1, 1);
    frames(6);
    wr_reg(8'h00, 16'h0400);
    wr_reg(8'h00, 16'h0200);
    inject(100);
    frames(14);
    rd_reg(8'h12, rd); check("R9 saturated count", int'(rd), (1 << EW) - 1);
  endtask

  task automatic t_disable;
    wr_cm(1, 1, 16'h8000, 1'b0);
    tx_seen = 0; tx_mis = 0; idle_mis = 0;
    frames(2);
    check("R3 other mode idles", idle_mis, 0);
    check("R3 no pattern bits", tx_mis, 0);
  endtask

  initial begin
    rst_n = 1'b0; cm_we = 1'b0; cm_addr = '0; cm_wdata = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    #1;
    t_reset;
    t_pattern;
    t_realign;
    t_count;
    t_stop;
    t_clear;
    t_resync;
    t_unlocked;
    t_saturate;
    t_disable;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule